// File: doc/BRIEF.md
# Indirect Memory Access Port

This block gives a host a narrow window into a large internal memory. The host sees only two control registers. One is a pointer register that holds a 32-bit internal address. The other is a data window through which the word at that address is read or written. The host first loads the pointer. Every later access through the data window then reaches the word the pointer names, until the pointer is loaded again.

The data window spans four consecutive byte offsets. An access carries a size code (byte, halfword or word). For byte and halfword accesses, the lane is taken from the low two bits of the window offset that the host accesses. The low bits of the stored pointer play no part in lane selection. Repeated accesses to the window never move the pointer, so a burst keeps hitting one word. Pointer chasing through tables in memory is done by the host in two steps: read a pointer word, load it into the pointer register, then access the target.

The internal storage is a word-wide RAM with one write strobe per byte. Data is little-endian within the word. Reads finish one cycle after the request, and a valid strobe marks the returned data.

Top module: `imp_port`

## Requirements
- R1: After reset the pointer register reads back as zero and `csr_rvalid` is low.
- R2: A write of any size to the pointer register offset (`ADDR_OFF`, low two offset bits ignored) stores all 32 bits of `csr_wdata`. A read there returns the stored value.
- R3: A read request produces `csr_rvalid` high, with its data, in exactly the cycle after the request. `csr_rvalid` is never high except after a read request.
- R4: A byte access (size code 0) to window offset `DATA_OFF+k` touches only bits [8k+7:8k] of the addressed word. A write leaves the other three bytes unchanged. A read returns the byte zero-extended in `csr_rdata[7:0]`.
- R5: A halfword access (size code 1) uses bytes 0–1 when offset bit 1 is 0 and bytes 2–3 when it is 1. Offset bit 0 is ignored. Reads are zero-extended.
- R6: A word access (size codes 2 and 3) reads or writes the whole word at any window offset.
- R7: The word index is taken from pointer bits [IDX_W+1:2]. The two low pointer bits are ignored. Higher bits wrap modulo `MEM_WORDS`.
- R8: Data window accesses never change the pointer register. Consecutive accesses therefore all reach the same word.
- R9: Reads of offsets outside both registers return zero with `csr_rvalid`. Writes there change neither the pointer nor the memory.
- R10: A pointer value read from memory through the window, written back into the pointer register, selects the target word for the next window access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| csr_req | input | 1 | Register access request, one per cycle |
| csr_we | input | 1 | 1 = write, 0 = read |
| csr_off | input | CSR_AW | Register byte offset |
| csr_size | input | 2 | 0 byte, 1 halfword, 2 or 3 word |
| csr_wdata | input | 32 | Write data, right-aligned for narrow writes |
| csr_rdata | output | 32 | Read data, valid with csr_rvalid |
| csr_rvalid | output | 1 | Read data valid, one cycle after a read request |

## Verification
The bench builds the port with `MEM_WORDS` set to 64. At that size a pointer of 0x123 folds onto the same word as 0x20, so wrap-around and the ignored low pointer bits can be checked by reading data written under the other alias. The register offsets stay at their defaults, 0x10 for the pointer and 0x14 for the window. Offset 0x00 is therefore an unmapped location for the read-as-zero and write-ignored cases.

// File: rtl/imp_pkg.sv
package imp_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_HALF = 2'd1,
      SZ_WORD = 2'd2,
      SZ_WIDE = 2'd3
   } acc_size_e;

   typedef enum logic [1:0] {
      TGT_NONE = 2'd0,
      TGT_PTR  = 2'd1,
      TGT_WIN  = 2'd2
   } tgt_e;

   typedef struct packed {
      tgt_e      tgt;
      acc_size_e size;
      logic [1:0] lane;
   } rd_ctx_t;

   // byte strobes covered by an access of a given size at a given lane
   function automatic logic [3:0] lane_mask(acc_size_e sz, logic [1:0] lane);
      logic [3:0] m;
      case (sz)
         SZ_BYTE: m = 4'b0001 << lane;
         SZ_HALF: m = lane[1] ? 4'b1100 : 4'b0011;
         default: m = 4'b1111;
      endcase
      return m;
   endfunction

endpackage

// File: rtl/imp_csr_decode.sv
module imp_csr_decode
   import imp_pkg::*;
#(
   parameter int          CSR_AW   = 8,
   parameter logic [CSR_AW-1:0] ADDR_OFF = 8'h10,
   parameter logic [CSR_AW-1:0] DATA_OFF = 8'h14,
   parameter int          PTR_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic              we,
   input  logic [CSR_AW-1:0] off,
   input  logic [PTR_W-1:0]  wdata,
   output logic [PTR_W-1:0]  ptr_q,
   output tgt_e              tgt,
   output logic [1:0]        lane
);

   localparam int SLOT_W = CSR_AW - 2;

   logic [SLOT_W-1:0] slot;
   logic              hit_ptr;
   logic              hit_win;

   assign slot    = off[CSR_AW-1:2];
   assign hit_ptr = (slot == ADDR_OFF[CSR_AW-1:2]);
   assign hit_win = (slot == DATA_OFF[CSR_AW-1:2]);
   assign lane    = off[1:0];

   always_comb begin
      if (hit_ptr)      tgt = TGT_PTR;
      else if (hit_win) tgt = TGT_WIN;
      else              tgt = TGT_NONE;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q <= '0;
      end else if (req && we && hit_ptr) begin
         ptr_q <= wdata;
      end
   end

endmodule

// File: rtl/imp_lane_steer.sv
module imp_lane_steer
   import imp_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  acc_size_e         wr_size,
   input  logic [1:0]        wr_lane,
   input  logic [DATA_W-1:0] host_wdata,
   output logic [DATA_W-1:0] ram_wdata,
   output logic [3:0]        ram_be,
   input  acc_size_e         rd_size,
   input  logic [1:0]        rd_lane,
   input  logic [DATA_W-1:0] ram_rdata,
   output logic [DATA_W-1:0] host_rdata
);

   localparam int LANES = DATA_W / 8;

   assign ram_be = lane_mask(wr_size, wr_lane);

   // replicate narrow write data onto every lane it may land in
   for (genvar g = 0; g < LANES; g++) begin : g_wlane
      always_comb begin
         case (wr_size)
            SZ_BYTE: ram_wdata[8*g +: 8] = host_wdata[7:0];
            SZ_HALF: ram_wdata[8*g +: 8] = host_wdata[8*(g%2) +: 8];
            default: ram_wdata[8*g +: 8] = host_wdata[8*g +: 8];
         endcase
      end
   end

   logic [7:0]  rd_byte;
   logic [15:0] rd_half;

   always_comb begin
      rd_byte = 8'h00;
      for (int k = 0; k < LANES; k++) begin
         if (rd_lane == k[1:0]) rd_byte = ram_rdata[8*k +: 8];
      end
      rd_half = rd_lane[1] ? ram_rdata[31:16] : ram_rdata[15:0];
      case (rd_size)
         SZ_BYTE: host_rdata = {{(DATA_W-8){1'b0}}, rd_byte};
         SZ_HALF: host_rdata = {{(DATA_W-16){1'b0}}, rd_half};
         default: host_rdata = ram_rdata;
      endcase
   end

endmodule

// File: rtl/imp_word_ram.sv
module imp_word_ram #(
   parameter int WORDS  = 512,
   parameter int DATA_W = 32,
   localparam int IDX_W = $clog2(WORDS),
   localparam int LANES = DATA_W / 8
) (
   input  logic              clk,
   input  logic              en,
   input  logic              we,
   input  logic [LANES-1:0]  be,
   input  logic [IDX_W-1:0]  idx,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] rdata
);

   for (genvar g = 0; g < LANES; g++) begin : g_bank
      logic [7:0] bank [WORDS];
      logic [7:0] rd_b;

      always_ff @(posedge clk) begin
         if (en && we && be[g]) begin
            bank[idx] <= wdata[8*g +: 8];
         end
         if (en && !we) begin
            rd_b <= bank[idx];
         end
      end

      assign rdata[8*g +: 8] = rd_b;
   end

endmodule

// File: rtl/imp_port.sv
module imp_port
   import imp_pkg::*;
#(
   parameter int                CSR_AW    = 8,
   parameter logic [CSR_AW-1:0] ADDR_OFF  = 8'h10,
   parameter logic [CSR_AW-1:0] DATA_OFF  = 8'h14,
   parameter int                MEM_WORDS = 512
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_req,
   input  logic              csr_we,
   input  logic [CSR_AW-1:0] csr_off,
   input  logic [1:0]        csr_size,
   input  logic [31:0]       csr_wdata,
   output logic [31:0]       csr_rdata,
   output logic              csr_rvalid
);

   localparam int DATA_W = 32;
   localparam int PTR_W  = 32;
   localparam int IDX_W  = $clog2(MEM_WORDS);

   if (MEM_WORDS < 2 || (1 << IDX_W) != MEM_WORDS) begin : g_bad_depth
      $error("imp_port: MEM_WORDS must be a power of two of at least 2");
   end
   if (IDX_W + 2 > PTR_W) begin : g_bad_span
      $error("imp_port: MEM_WORDS exceeds the pointer range");
   end
   if (ADDR_OFF[1:0] != 2'b00 || DATA_OFF[1:0] != 2'b00) begin : g_bad_align
      $error("imp_port: register offsets must be word aligned");
   end
   if (ADDR_OFF == DATA_OFF) begin : g_bad_overlap
      $error("imp_port: pointer and window offsets must differ");
   end

   acc_size_e         size_in;
   tgt_e              tgt;
   logic [1:0]        lane;
   logic [PTR_W-1:0]  addr_q;
   logic [IDX_W-1:0]  ram_idx;
   logic              ram_en;
   logic              ram_we;
   logic [3:0]        ram_be;
   logic [3:0]        steer_be;
   logic [DATA_W-1:0] ram_wdata;
   logic [DATA_W-1:0] ram_rdata;
   logic [DATA_W-1:0] win_rdata;
   rd_ctx_t           ctx_q;
   logic              rvalid_q;

   assign size_in = acc_size_e'(csr_size);

   imp_csr_decode #(
      .CSR_AW  (CSR_AW),
      .ADDR_OFF(ADDR_OFF),
      .DATA_OFF(DATA_OFF),
      .PTR_W   (PTR_W)
   ) u_dec (
      .clk  (clk),
      .rst_n(rst_n),
      .req  (csr_req),
      .we   (csr_we),
      .off  (csr_off),
      .wdata(csr_wdata),
      .ptr_q(addr_q),
      .tgt  (tgt),
      .lane (lane)
   );

   // word index comes from the pointer; low pointer bits never pick a lane
   assign ram_idx = addr_q[2 +: IDX_W];
   assign ram_en  = csr_req && (tgt == TGT_WIN);
   assign ram_we  = ram_en && csr_we;
   assign ram_be  = ram_we ? steer_be : 4'b0000;

   imp_lane_steer #(
      .DATA_W(DATA_W)
   ) u_steer (
      .wr_size   (size_in),
      .wr_lane   (lane),
      .host_wdata(csr_wdata),
      .ram_wdata (ram_wdata),
      .ram_be    (steer_be),
      .rd_size   (ctx_q.size),
      .rd_lane   (ctx_q.lane),
      .ram_rdata (ram_rdata),
      .host_rdata(win_rdata)
   );

   imp_word_ram #(
      .WORDS (MEM_WORDS),
      .DATA_W(DATA_W)
   ) u_ram (
      .clk  (clk),
      .en   (ram_en),
      .we   (ram_we),
      .be   (ram_be),
      .idx  (ram_idx),
      .wdata(ram_wdata),
      .rdata(ram_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rvalid_q <= 1'b0;
         ctx_q    <= '{tgt: TGT_NONE, size: SZ_WORD, lane: 2'b00};
      end else begin
         rvalid_q <= csr_req && !csr_we;
         if (csr_req && !csr_we) begin
            ctx_q <= '{tgt: tgt, size: size_in, lane: lane};
         end
      end
   end

   always_comb begin
      case (ctx_q.tgt)
         TGT_PTR: csr_rdata = addr_q;
         TGT_WIN: csr_rdata = win_rdata;
         default: csr_rdata = '0;
      endcase
      if (!rvalid_q) csr_rdata = '0;
   end

   assign csr_rvalid = rvalid_q;

endmodule

// File: rtl/imp_port_chk.sv
module imp_port_chk #(
   parameter int                CSR_AW   = 8,
   parameter logic [CSR_AW-1:0] ADDR_OFF = 8'h10,
   parameter logic [CSR_AW-1:0] DATA_OFF = 8'h14
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_req,
   input logic              csr_we,
   input logic [CSR_AW-1:0] csr_off,
   input logic [1:0]        csr_size,
   input logic [31:0]       csr_wdata,
   input logic [31:0]       csr_rdata,
   input logic              csr_rvalid,
   input logic [31:0]       addr_q,
   input logic              ram_we,
   input logic [3:0]        ram_be
);

   logic rd_req, wr_req, at_ptr, at_win;
   assign rd_req = csr_req && !csr_we;
   assign wr_req = csr_req && csr_we;
   assign at_ptr = (csr_off[CSR_AW-1:2] == ADDR_OFF[CSR_AW-1:2]);
   assign at_win = (csr_off[CSR_AW-1:2] == DATA_OFF[CSR_AW-1:2]);

   AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req |=> csr_rvalid); // R3
   AST_RVALID_ONLY_READ: assert property (@(posedge clk) disable iff (!rst_n)
      csr_rvalid |-> $past(rd_req)); // R3
   AST_PTR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && at_ptr) |=> addr_q == $past(csr_wdata)); // R2
   AST_PTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_req && at_ptr) |=> $stable(addr_q)); // R8
   AST_BYTE_ONE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && at_win && csr_size == 2'd0) |-> $countones(ram_be) == 1); // R4
   AST_HALF_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && at_win && csr_size == 2'd1) |-> (ram_be == 4'b0011 || ram_be == 4'b1100)); // R5
   AST_BYTE_READ_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rvalid && $past(at_win && csr_size == 2'd0)) |-> csr_rdata[31:8] == 24'h0); // R4
   AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_rvalid && $past(!at_ptr && !at_win)) |-> csr_rdata == 32'h0); // R9
   AST_UNMAPPED_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_req && !at_win) |-> (!ram_we && ram_be == 4'b0000)); // R9

endmodule

bind imp_port imp_port_chk #(
   .CSR_AW  (CSR_AW),
   .ADDR_OFF(ADDR_OFF),
   .DATA_OFF(DATA_OFF)
) u_chk (.*);

// File: tb/tb_imp_port.sv
module tb_imp_port;

   localparam int CLK_PERIOD = 10;
   localparam int AW         = 8;
   localparam logic [7:0] PTR = 8'h10;
   localparam logic [7:0] WIN = 8'h14;
   localparam int NVEC = 19;

   // {we, size[1:0], off[7:0], data[31:0], expect[31:0]}
   localparam logic [74:0] VEC [NVEC] = '{
      {1'b1, 2'd2, 8'h10, 32'h0000_0020, 32'h0},            // R2
      {1'b1, 2'd2, 8'h14, 32'hA1B2_C3D4, 32'h0},            // R6
      {1'b0, 2'd2, 8'h14, 32'h0, 32'hA1B2_C3D4},            // R6
      {1'b0, 2'd0, 8'h14, 32'h0, 32'h0000_00D4},            // R4
      {1'b0, 2'd0, 8'h15, 32'h0, 32'h0000_00C3},            // R4
      {1'b0, 2'd0, 8'h17, 32'h0, 32'h0000_00A1},            // R4
      {1'b0, 2'd1, 8'h14, 32'h0, 32'h0000_C3D4},            // R5
      {1'b0, 2'd1, 8'h16, 32'h0, 32'h0000_A1B2},            // R5
      {1'b0, 2'd1, 8'h17, 32'h0, 32'h0000_A1B2},            // R5 bit0 ignored
      {1'b1, 2'd0, 8'h16, 32'hFFFF_FF55, 32'h0},            // R4
      {1'b0, 2'd2, 8'h14, 32'h0, 32'hA155_C3D4},            // R4
      {1'b1, 2'd1, 8'h15, 32'hEEEE_1234, 32'h0},            // R5
      {1'b0, 2'd3, 8'h16, 32'h0, 32'hA155_1234},            // R6 size 3 at any offset
      {1'b0, 2'd2, 8'h10, 32'h0, 32'h0000_0020},            // R2
      {1'b1, 2'd0, 8'h10, 32'h0000_0123, 32'h0},            // R2 any size, full value
      {1'b0, 2'd2, 8'h10, 32'h0, 32'h0000_0123},            // R2
      {1'b0, 2'd0, 8'h14, 32'h0, 32'h0000_0034},            // R7 alias, lane from offset
      {1'b0, 2'd2, 8'h00, 32'h0, 32'h0},                    // R9
      {1'b0, 2'd2, 8'h14, 32'h0, 32'hA155_1234}             // R7
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_req = 1'b0;
   logic        csr_we = 1'b0;
   logic [7:0]  csr_off = '0;
   logic [1:0]  csr_size = '0;
   logic [31:0] csr_wdata = '0;
   logic [31:0] csr_rdata;
   logic        csr_rvalid;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   imp_port #(
      .CSR_AW   (AW),
      .ADDR_OFF (PTR),
      .DATA_OFF (WIN),
      .MEM_WORDS(64)
   ) dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .csr_req   (csr_req),
      .csr_we    (csr_we),
      .csr_off   (csr_off),
      .csr_size  (csr_size),
      .csr_wdata (csr_wdata),
      .csr_rdata (csr_rdata),
      .csr_rvalid(csr_rvalid)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // called at a falling edge; returns at the next falling edge with the result
   task automatic acc(input logic we, input logic [1:0] sz, input logic [7:0] off,
                      input logic [31:0] d, output logic [31:0] rd, output logic rv);
      csr_req   = 1'b1;
      csr_we    = we;
      csr_size  = sz;
      csr_off   = off;
      csr_wdata = d;
      @(posedge clk);
      @(negedge clk);
      rd = csr_rdata;
      rv = csr_rvalid;
      csr_req = 1'b0;
      csr_we  = 1'b0;
   endtask

   task automatic rd_word(input logic [7:0] off, input logic [1:0] sz, input string req,
                          input logic [31:0] exp);
      logic [31:0] r;
      logic        v;
      acc(1'b0, sz, off, 32'h0, r, v);
      check(req, {31'h0, v}, 32'h1);
      check(req, r, exp);
   endtask

   task automatic wr(input logic [7:0] off, input logic [1:0] sz, input logic [31:0] d);
      logic [31:0] r;
      logic        v;
      acc(1'b1, sz, off, d, r, v);
      check("R3 no rvalid on write", {31'h0, v}, 32'h0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      finish_run();
   end

   initial begin
      logic [31:0] r;
      logic        v;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 rvalid after reset", {31'h0, csr_rvalid}, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);
      rd_word(PTR, 2'd2, "R1 pointer reset", 32'h0);

      // vector table
      for (int i = 0; i < NVEC; i++) begin
         acc(VEC[i][74], VEC[i][73:72], VEC[i][71:64], VEC[i][63:32], r, v);
         if (VEC[i][74]) begin
            check($sformatf("R3 vec %0d no rvalid", i), {31'h0, v}, 32'h0);
         end else begin
            check($sformatf("R3 vec %0d rvalid", i), {31'h0, v}, 32'h1);
            check($sformatf("R4/R5/R6 vec %0d data", i), r, VEC[i][31:0]);
         end
      end

      // R3: valid lasts one cycle after an isolated read
      acc(1'b0, 2'd2, WIN, 32'h0, r, v);
      @(negedge clk);
      check("R3 rvalid single cycle", {31'h0, csr_rvalid}, 32'h0);

      // R8: window burst keeps the same word
      wr(PTR, 2'd2, 32'h0000_0044);
      wr(WIN, 2'd2, 32'h0BAD_F00D);
      wr(PTR, 2'd2, 32'h0000_0040);
      wr(WIN, 2'd2, 32'h1111_1111);
      wr(WIN, 2'd0, 32'h0000_0022);
      wr(WIN, 2'd2, 32'h3333_3333);
      rd_word(WIN, 2'd2, "R8 burst last write wins", 32'h3333_3333);
      rd_word(WIN, 2'd2, "R8 repeat read same word", 32'h3333_3333);
      rd_word(PTR, 2'd2, "R8 pointer unchanged", 32'h0000_0040);
      wr(PTR, 2'd2, 32'h0000_0044);
      rd_word(WIN, 2'd2, "R8 neighbour untouched", 32'h0BAD_F00D);

      // R9: write to unmapped offset changes nothing
      wr(8'h00, 2'd2, 32'hDEAD_BEEF);
      wr(8'h1C, 2'd0, 32'h0000_0077);
      rd_word(PTR, 2'd2, "R9 pointer kept", 32'h0000_0044);
      rd_word(WIN, 2'd2, "R9 memory kept", 32'h0BAD_F00D);
      rd_word(8'h20, 2'd0, "R9 unmapped reads zero", 32'h0);

      // R10: two-step pointer lookup
      wr(PTR, 2'd2, 32'h0000_00C8);
      wr(WIN, 2'd2, 32'h0000_5EED);
      wr(PTR, 2'd2, 32'h0000_0080);
      wr(WIN, 2'd2, 32'h0000_00C8);
      acc(1'b0, 2'd2, WIN, 32'h0, r, v);
      check("R10 pointer word", r, 32'h0000_00C8);
      wr(PTR, 2'd2, r);
      rd_word(WIN, 2'd2, "R10 target word", 32'h0000_5EED);

      // R1: reset clears pointer again
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      rd_word(PTR, 2'd2, "R1 pointer after second reset", 32'h0);

      finish_run();
   end

endmodule